// File: doc/BRIEF.md
# Snooping Coherent Crossbar

This block joins N upstream agents (processors, caches, DMA engines) to M downstream targets plus one default target. A request from an upstream agent goes to the downstream port whose inclusive address window holds the request address; an address outside every window goes to the default port. When a request is cacheable and the global cache-bypass pin is low, the crossbar broadcasts it in the same cycle as a snoop to every upstream port marked as snooping, except the requester. Snoop requests that a downstream target raises are broadcast to every snooping upstream port, with none left out.

The crossbar keeps an outstanding table indexed by transaction ID. A request that expects an answer is entered in it on acceptance, together with its requester index. A response from downstream looks up the table by ID and is steered back to that requester. A snoop response from an upstream agent also looks up the table. On a hit, the snoop response finishes the tracked request and is delivered to the original requester on a separate fill channel. On a miss, it is forwarded downstream as a snoop response to the port named by its destination field.

Requests, responses and snoop responses use three independent channels, and each has its own one-per-cycle occupancy. All data channels use valid/ready. Only the request channel stalls for coherence reasons. Response and snoop-response inputs see ready low only while another input of the same channel holds that cycle. Upstream response, fill and snoop outputs and downstream snoop-response outputs have no ready: their receivers must always take them. The downstream snoop input has no ready either, because it is never refused.

Top module: `cxb_coherent_xbar`

## Requirements
- R1: When a cacheable request is accepted, cache_bypass is low and dn_snp_valid is low, up_snp_valid in that same cycle equals SNOOP_MASK with the requester's bit cleared. up_snp_addr and up_snp_id carry the request's address and ID.
- R2: An accepted request that is uncacheable, or any accepted request while cache_bypass is high, raises no up_snp_valid bit.
- R3: The winning request drives exactly one dn_req_valid bit. That bit is downstream port k when base_k <= addr <= limit_k, with the lowest k winning if windows overlap; otherwise it is the default port, index M. dn_req_addr, dn_req_id and dn_req_src (the requester index) come with it.
- R4: A request with needrsp high and express low is recorded under its ID when accepted. While that ID is recorded, every such request with the same ID is held with ready low, so a full table stalls all such requests. If the selected downstream port has ready low, no upstream ready rises and nothing is recorded.
- R5: The lowest-indexed valid downstream response is accepted each cycle. In the same cycle it appears on up_rsp_valid at the recorded requester, with up_rsp_id equal to its ID, and the table entry is free from the next cycle.
- R6: The lowest-indexed valid upstream snoop response is accepted each cycle. If its ID is recorded, it appears on up_fill_valid at the recorded requester with up_fill_id, and the entry is freed.
- R7: An accepted snoop response whose ID is not recorded appears on dn_sresp_valid at the port given by its destination field, with dn_sresp_id equal to its ID, and the table is left unchanged.
- R8: While dn_snp_valid is high, up_snp_valid equals SNOOP_MASK and carries dn_snp_addr and dn_snp_id. In that cycle cacheable requests (when cache_bypass is low) are held, and other requests may still be accepted.
- R9: Express requests are never held by the table and are never recorded. When any eligible express request exists, only express requests compete for the grant.
- R10: The response and snoop-response channels each accept one input per cycle, whatever the request channel is doing.
- R11: Request arbitration is round robin: after an accepted grant to port i, the search starts at port i+1 (wrapping), and a grant that is not accepted does not move the pointer.
- R12: After reset the table is empty, the first search starts at port 0, and with all inputs idle every valid and ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_bypass | input | 1 | Global: suppress all request snoops |
| cfg_base | input | M*AW | Per-downstream-port window base, port k at [k*AW +: AW] |
| cfg_limit | input | M*AW | Per-downstream-port inclusive window limit |
| up_req_valid | input | N | Upstream request valid |
| up_req_ready | output | N | Upstream request accepted; low means retry |
| up_req_addr | input | N*AW | Request address per upstream port |
| up_req_id | input | N*IW | Transaction ID per upstream port |
| up_req_cacheable | input | N | Request may be snooped |
| up_req_needrsp | input | N | Request expects a response |
| up_req_express | input | N | Express request: priority, untracked |
| dn_req_valid | output | M+1 | Request valid per downstream port (index M is default) |
| dn_req_ready | input | M+1 | Downstream request ready |
| dn_req_addr | output | AW | Forwarded request address |
| dn_req_id | output | IW | Forwarded request ID |
| dn_req_src | output | $clog2(N) | Requester index |
| up_snp_valid | output | N | Snoop request to each upstream port |
| up_snp_addr | output | AW | Snoop address |
| up_snp_id | output | IW | Snoop ID |
| dn_snp_valid | input | 1 | Snoop request from downstream (never refused) |
| dn_snp_addr | input | AW | Downstream snoop address |
| dn_snp_id | input | IW | Downstream snoop ID |
| dn_rsp_valid | input | M+1 | Response valid per downstream port |
| dn_rsp_ready | output | M+1 | Response accepted |
| dn_rsp_id | input | (M+1)*IW | Response ID per downstream port |
| up_rsp_valid | output | N | Response to upstream port |
| up_rsp_id | output | IW | Response ID |
| up_sresp_valid | input | N | Snoop response valid per upstream port |
| up_sresp_ready | output | N | Snoop response accepted |
| up_sresp_id | input | N*IW | Snoop response ID per upstream port |
| up_sresp_dest | input | N*$clog2(M+1) | Downstream destination per snoop response |
| up_fill_valid | output | N | Snoop response delivered as a response to upstream |
| up_fill_id | output | IW | Fill ID |
| dn_sresp_valid | output | M+1 | Snoop response forwarded downstream |
| dn_sresp_id | output | IW | Forwarded snoop response ID |

## Verification
The bench targets table-driven decisions. A request that reuses a busy ID must stall, or a second entry would overwrite the first and its answer would go to the wrong port. A snoop response that hits the table must become a fill, and one that misses must go downstream, so swapped paths show up as traffic on the wrong output. A refused downstream request must leave the table and the arbitration pointer untouched, or later answers would be misrouted and fairness would slip. It also mixes downstream snoops with cacheable and uncacheable requests, the bypass pin and express traffic, to catch a requester snooped by its own request or a bypass that fails to silence the broadcast.

// File: rtl/cxb_pkg.sv
package cxb_pkg;
  typedef enum logic [1:0] {
    SR_IDLE = 2'd0,
    SR_FILL = 2'd1,
    SR_FWD  = 2'd2
  } sresp_route_e;
endpackage

// File: rtl/cxb_addr_decode.sv
module cxb_addr_decode #(
  parameter int M  = 2,
  parameter int AW = 16,
  localparam int DW = $clog2(M + 1)
) (
  input  logic [AW-1:0]   addr,
  input  logic [M*AW-1:0] base,
  input  logic [M*AW-1:0] limit,
  output logic [DW-1:0]   port
);
  always_comb begin
    port = DW'(M);
    for (int k = M - 1; k >= 0; k--) begin
      if (addr >= base[k*AW +: AW] && addr <= limit[k*AW +: AW])
        port = DW'(k);
    end
  end
endmodule

// File: rtl/cxb_rr_arb.sv
module cxb_rr_arb #(
  parameter int W = 3,
  localparam int XW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  req,
  input  logic          adv,
  output logic [W-1:0]  grant,
  output logic [XW-1:0] idx,
  output logic          any
);
  logic [XW-1:0] last_q;

  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int k = 0; k < W; k++) begin
      int j;
      j = int'(last_q) + 1 + k;
      if (j >= W) j = j - W;
      if (!any && req[j]) begin
        any      = 1'b1;
        idx      = XW'(j);
        grant[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           last_q <= XW'(W - 1);
    else if (adv && any)  last_q <= idx;
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R11
  AST_ARB_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0); // R11
endmodule

// File: rtl/cxb_otable.sv
module cxb_otable #(
  parameter int IW = 3,
  parameter int SW = 2,
  localparam int T = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_id,
  input  logic [SW-1:0] set_src,
  input  logic          clra_en,
  input  logic [IW-1:0] clra_id,
  input  logic          clrb_en,
  input  logic [IW-1:0] clrb_id,
  output logic [T-1:0]    busy,
  output logic [T*SW-1:0] src
);
  for (genvar e = 0; e < T; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[e]           <= 1'b0;
        src[e*SW +: SW]   <= '0;
      end else if (set_en && set_id == IW'(e)) begin
        busy[e]           <= 1'b1;
        src[e*SW +: SW]   <= set_src;
      end else if ((clra_en && clra_id == IW'(e)) ||
                   (clrb_en && clrb_id == IW'(e))) begin
        busy[e]           <= 1'b0;
      end
    end
  end

  AST_SET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !busy[set_id]); // R4
  AST_RSP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    clra_en |-> busy[clra_id]); // R5
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy[$past(set_id)]); // R4
  AST_NO_DUAL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(clra_en && clrb_en && clra_id == clrb_id)); // R6
endmodule

// File: rtl/cxb_coherent_xbar.sv
module cxb_coherent_xbar
  import cxb_pkg::*;
#(
  parameter int N  = 3,
  parameter int M  = 2,
  parameter int AW = 16,
  parameter int IW = 3,
  parameter logic [N-1:0] SNOOP_MASK = '1,
  localparam int P  = M + 1,
  localparam int SW = $clog2(N),
  localparam int DW = $clog2(P),
  localparam int T  = 1 << IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cache_bypass,
  input  logic [M*AW-1:0] cfg_base,
  input  logic [M*AW-1:0] cfg_limit,
  input  logic [N-1:0]    up_req_valid,
  output logic [N-1:0]    up_req_ready,
  input  logic [N*AW-1:0] up_req_addr,
  input  logic [N*IW-1:0] up_req_id,
  input  logic [N-1:0]    up_req_cacheable,
  input  logic [N-1:0]    up_req_needrsp,
  input  logic [N-1:0]    up_req_express,
  output logic [P-1:0]    dn_req_valid,
  input  logic [P-1:0]    dn_req_ready,
  output logic [AW-1:0]   dn_req_addr,
  output logic [IW-1:0]   dn_req_id,
  output logic [SW-1:0]   dn_req_src,
  output logic [N-1:0]    up_snp_valid,
  output logic [AW-1:0]   up_snp_addr,
  output logic [IW-1:0]   up_snp_id,
  input  logic            dn_snp_valid,
  input  logic [AW-1:0]   dn_snp_addr,
  input  logic [IW-1:0]   dn_snp_id,
  input  logic [P-1:0]    dn_rsp_valid,
  output logic [P-1:0]    dn_rsp_ready,
  input  logic [P*IW-1:0] dn_rsp_id,
  output logic [N-1:0]    up_rsp_valid,
  output logic [IW-1:0]   up_rsp_id,
  input  logic [N-1:0]    up_sresp_valid,
  output logic [N-1:0]    up_sresp_ready,
  input  logic [N*IW-1:0] up_sresp_id,
  input  logic [N*DW-1:0] up_sresp_dest,
  output logic [N-1:0]    up_fill_valid,
  output logic [IW-1:0]   up_fill_id,
  output logic [P-1:0]    dn_sresp_valid,
  output logic [IW-1:0]   dn_sresp_id
);
  // shared outstanding table
  logic [T-1:0]    tbl_busy;
  logic [T*SW-1:0] tbl_src;
  logic            tbl_set;
  logic            rsp_any;
  logic [IW-1:0]   rsp_id;
  sresp_route_e    s_route;
  logic [IW-1:0]   s_id;

  // ---------------- request channel ----------------
  logic [N-1:0]  snp_need, tracked, elig, exp_elig, cand;
  logic [N-1:0]  req_grant;
  logic [SW-1:0] req_idx;
  logic          req_any, req_accept;
  logic [AW-1:0] w_addr;
  logic [IW-1:0] w_id;
  logic [DW-1:0] dport;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      snp_need[i] = up_req_cacheable[i] & ~cache_bypass;
      tracked[i]  = up_req_needrsp[i] & ~up_req_express[i];
      elig[i]     = up_req_valid[i]
                  & ~(snp_need[i] & dn_snp_valid)
                  & ~(tracked[i] & tbl_busy[up_req_id[i*IW +: IW]]);
    end
    exp_elig = elig & up_req_express;
    cand     = (|exp_elig) ? exp_elig : elig;
  end

  cxb_rr_arb #(.W(N)) u_req_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cand),
    .adv   (req_accept),
    .grant (req_grant),
    .idx   (req_idx),
    .any   (req_any)
  );

  assign w_addr = up_req_addr[req_idx*AW +: AW];
  assign w_id   = up_req_id[req_idx*IW +: IW];

  cxb_addr_decode #(.M(M), .AW(AW)) u_dec (
    .addr  (w_addr),
    .base  (cfg_base),
    .limit (cfg_limit),
    .port  (dport)
  );

  assign req_accept   = req_any & dn_req_ready[dport];
  assign dn_req_valid = req_any ? (P'(1) << dport) : '0;
  assign up_req_ready = req_accept ? req_grant : '0;
  assign dn_req_addr  = w_addr;
  assign dn_req_id    = w_id;
  assign dn_req_src   = req_idx;
  assign tbl_set      = req_accept & tracked[req_idx];

  // snoop broadcast: downstream snoop owns the bus when present
  always_comb begin
    up_snp_valid = '0;
    up_snp_addr  = w_addr;
    up_snp_id    = w_id;
    if (dn_snp_valid) begin
      up_snp_valid = SNOOP_MASK;
      up_snp_addr  = dn_snp_addr;
      up_snp_id    = dn_snp_id;
    end else if (req_accept && snp_need[req_idx]) begin
      up_snp_valid = SNOOP_MASK & ~req_grant;
    end
  end

  // ---------------- response channel ----------------
  logic [DW-1:0] rsp_sel;
  logic [SW-1:0] rsp_dst;

  always_comb begin
    rsp_any = 1'b0;
    rsp_sel = '0;
    for (int i = 0; i < P; i++) begin
      if (dn_rsp_valid[i] && !rsp_any) begin
        rsp_any = 1'b1;
        rsp_sel = DW'(i);
      end
    end
  end

  assign rsp_id       = dn_rsp_id[rsp_sel*IW +: IW];
  assign rsp_dst      = tbl_src[rsp_id*SW +: SW];
  assign dn_rsp_ready = rsp_any ? (P'(1) << rsp_sel) : '0;
  assign up_rsp_valid = rsp_any ? (N'(1) << rsp_dst) : '0;
  assign up_rsp_id    = rsp_id;

  // ---------------- snoop-response channel ----------------
  logic          s_any;
  logic [SW-1:0] s_sel;
  logic [DW-1:0] s_dest;
  logic [SW-1:0] s_owner;

  always_comb begin
    s_any = 1'b0;
    s_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (up_sresp_valid[i] && !s_any) begin
        s_any = 1'b1;
        s_sel = SW'(i);
      end
    end
  end

  assign s_id    = up_sresp_id[s_sel*IW +: IW];
  assign s_dest  = up_sresp_dest[s_sel*DW +: DW];
  assign s_owner = tbl_src[s_id*SW +: SW];

  always_comb begin
    if (!s_any)              s_route = SR_IDLE;
    else if (tbl_busy[s_id]) s_route = SR_FILL;
    else                     s_route = SR_FWD;
  end

  assign up_sresp_ready = s_any ? (N'(1) << s_sel) : '0;
  assign up_fill_valid  = (s_route == SR_FILL) ? (N'(1) << s_owner) : '0;
  assign up_fill_id     = s_id;
  assign dn_sresp_valid = (s_route == SR_FWD) ? (P'(1) << s_dest) : '0;
  assign dn_sresp_id    = s_id;

  cxb_otable #(.IW(IW), .SW(SW)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (tbl_set),
    .set_id  (w_id),
    .set_src (req_idx),
    .clra_en (rsp_any),
    .clra_id (rsp_id),
    .clrb_en (s_route == SR_FILL),
    .clrb_id (s_id),
    .busy    (tbl_busy),
    .src     (tbl_src)
  );

  AST_SNOOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_snp_valid |-> (up_snp_valid & up_req_ready) == '0); // R1
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_bypass && !dn_snp_valid) |-> up_snp_valid == '0); // R2
  AST_DN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_req_valid)); // R3
  AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_req_valid & ~dn_req_ready) != '0) |-> up_req_ready == '0); // R4
  AST_FILL_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fill_valid != '0) |-> (up_fill_valid & up_sresp_ready) == '0); // R6
  AST_SRESP_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !((up_fill_valid != '0) && (dn_sresp_valid != '0))); // R7
  AST_DNSNP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_snp_valid |-> up_snp_valid == SNOOP_MASK); // R8
endmodule

// File: tb/sim_cxb_coherent_xbar.sv
module sim_cxb_coherent_xbar;
  localparam int N = 3, M = 2, P = 3, AW = 16, IW = 3, SW = 2, DW = 2, T = 8;
  localparam logic [N-1:0] SMASK = 3'b011;
  localparam int CYCLES = 4000;

  logic clk = 1'b0, rst_n = 1'b0, cache_bypass = 1'b0;
  logic [M*AW-1:0] cfg_base  = {16'h4000, 16'h0000};
  logic [M*AW-1:0] cfg_limit = {16'h7FFF, 16'h3FFF};
  logic [N-1:0] up_req_valid = '0, up_req_ready, up_req_cacheable = '0,
                up_req_needrsp = '0, up_req_express = '0;
  logic [N*AW-1:0] up_req_addr = '0;
  logic [N*IW-1:0] up_req_id = '0;
  logic [P-1:0] dn_req_valid, dn_req_ready = '0;
  logic [AW-1:0] dn_req_addr;
  logic [IW-1:0] dn_req_id;
  logic [SW-1:0] dn_req_src;
  logic [N-1:0] up_snp_valid;
  logic [AW-1:0] up_snp_addr;
  logic [IW-1:0] up_snp_id;
  logic dn_snp_valid = 1'b0;
  logic [AW-1:0] dn_snp_addr = '0;
  logic [IW-1:0] dn_snp_id = '0;
  logic [P-1:0] dn_rsp_valid = '0, dn_rsp_ready;
  logic [P*IW-1:0] dn_rsp_id = '0;
  logic [N-1:0] up_rsp_valid;
  logic [IW-1:0] up_rsp_id;
  logic [N-1:0] up_sresp_valid = '0, up_sresp_ready;
  logic [N*IW-1:0] up_sresp_id = '0;
  logic [N*DW-1:0] up_sresp_dest = '0;
  logic [N-1:0] up_fill_valid;
  logic [IW-1:0] up_fill_id;
  logic [P-1:0] dn_sresp_valid;
  logic [IW-1:0] dn_sresp_id;

  cxb_coherent_xbar #(.N(N), .M(M), .AW(AW), .IW(IW), .SNOOP_MASK(SMASK)) u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mbusy[T];
  int msrc[T];
  int mptr;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  // behavioural reference: compare current outputs, then advance state
  task automatic model_step();
    int w, port, rs, ss, rid, sid, owner;
    bit acc, tr_w;
    logic [N-1:0] el, ex, cand, e_ready, e_snp, e_fill;
    logic [P-1:0] e_dnv, e_dnrdy, e_fwd;
    logic [N-1:0] e_rsp, e_srdy;
    int waddr, wid;
    w = -1;
    for (int i = 0; i < N; i++) begin
      bit sn, tr;
      sn = up_req_cacheable[i] && !cache_bypass;
      tr = up_req_needrsp[i] && !up_req_express[i];
      el[i] = up_req_valid[i] && !(sn && dn_snp_valid) &&
              !(tr && mbusy[up_req_id[i*IW +: IW]]);
    end
    ex = el & up_req_express;
    cand = (ex != 0) ? ex : el;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (mptr + 1 + k) % N;
      if (w < 0 && cand[j]) w = j;
    end
    port = M; waddr = 0; wid = 0; acc = 0; tr_w = 0;
    e_ready = '0; e_dnv = '0; e_snp = '0;
    if (w >= 0) begin
      waddr = up_req_addr[w*AW +: AW];
      wid   = up_req_id[w*IW +: IW];
      for (int k = M - 1; k >= 0; k--)
        if (waddr >= cfg_base[k*AW +: AW] && waddr <= cfg_limit[k*AW +: AW]) port = k;
      e_dnv[port] = 1'b1;
      acc = dn_req_ready[port];
      if (acc) e_ready[w] = 1'b1;
      tr_w = up_req_needrsp[w] && !up_req_express[w];
    end
    if (dn_snp_valid) e_snp = SMASK;
    else if (acc && up_req_cacheable[w] && !cache_bypass) begin
      e_snp = SMASK; e_snp[w] = 1'b0;
    end
    // R4 R9 R11: grant, stall and retry decisions
    chk("R4 R9 R11 up_req_ready", up_req_ready, e_ready);
    chk("R3 dn_req_valid", dn_req_valid, e_dnv);
    if (e_dnv != 0) begin
      chk("R3 dn_req_addr", dn_req_addr, waddr);
      chk("R3 dn_req_id", dn_req_id, wid);
      chk("R3 dn_req_src", dn_req_src, w);
    end
    chk("R1 R2 R8 up_snp_valid", up_snp_valid, e_snp);
    if (e_snp != 0) begin
      chk("R1 R8 up_snp_addr", up_snp_addr, dn_snp_valid ? int'(dn_snp_addr) : waddr);
      chk("R1 R8 up_snp_id", up_snp_id, dn_snp_valid ? int'(dn_snp_id) : wid);
    end
    // response channel
    rs = -1; e_dnrdy = '0; e_rsp = '0; rid = 0;
    for (int i = 0; i < P; i++) if (rs < 0 && dn_rsp_valid[i]) rs = i;
    if (rs >= 0) begin
      rid = dn_rsp_id[rs*IW +: IW];
      e_dnrdy[rs] = 1'b1;
      e_rsp[msrc[rid]] = 1'b1;
    end
    chk("R10 dn_rsp_ready", dn_rsp_ready, e_dnrdy);
    chk("R5 up_rsp_valid", up_rsp_valid, e_rsp);
    if (rs >= 0) chk("R5 up_rsp_id", up_rsp_id, rid);
    // snoop-response channel
    ss = -1; e_srdy = '0; e_fill = '0; e_fwd = '0; sid = 0; owner = -1;
    for (int i = 0; i < N; i++) if (ss < 0 && up_sresp_valid[i]) ss = i;
    if (ss >= 0) begin
      sid = up_sresp_id[ss*IW +: IW];
      e_srdy[ss] = 1'b1;
      if (mbusy[sid]) begin owner = msrc[sid]; e_fill[owner] = 1'b1; end
      else e_fwd[up_sresp_dest[ss*DW +: DW]] = 1'b1;
    end
    chk("R10 up_sresp_ready", up_sresp_ready, e_srdy);
    chk("R6 up_fill_valid", up_fill_valid, e_fill);
    if (e_fill != 0) chk("R6 up_fill_id", up_fill_id, sid);
    chk("R7 dn_sresp_valid", dn_sresp_valid, e_fwd);
    if (e_fwd != 0) chk("R7 dn_sresp_id", dn_sresp_id, sid);
    // advance state
    if (rs >= 0) mbusy[rid] = 0;
    if (owner >= 0) mbusy[sid] = 0;
    if (acc && tr_w) begin mbusy[wid] = 1; msrc[wid] = w; end
    if (acc) mptr = w;
  endtask

  task automatic drive_random();
    cache_bypass = ($urandom % 10) == 0;
    for (int i = 0; i < N; i++) begin
      up_req_valid[i]     = ($urandom % 10) < 6;
      up_req_addr[i*AW +: AW] = AW'($urandom);
      up_req_id[i*IW +: IW]   = IW'($urandom);
      up_req_cacheable[i] = ($urandom % 3) != 0;
      up_req_needrsp[i]   = ($urandom % 5) != 0;
      up_req_express[i]   = ($urandom % 8) == 0;
    end
    for (int k = 0; k < P; k++) begin
      int id;
      dn_req_ready[k] = ($urandom % 4) != 0;
      id = $urandom % T;
      dn_rsp_id[k*IW +: IW] = IW'(id);
      dn_rsp_valid[k] = (($urandom % 4) == 0) && mbusy[id];
    end
    dn_snp_valid = ($urandom % 6) == 0;
    dn_snp_addr  = AW'($urandom);
    dn_snp_id    = IW'($urandom);
    for (int i = 0; i < N; i++) begin
      int id;
      bit clash;
      id = $urandom % T;
      clash = 0;
      for (int k = 0; k < P; k++)
        if (dn_rsp_valid[k] && int'(dn_rsp_id[k*IW +: IW]) == id) clash = 1;
      up_sresp_id[i*IW +: IW]   = IW'(id);
      up_sresp_dest[i*DW +: DW] = DW'($urandom % P);
      up_sresp_valid[i] = (($urandom % 4) == 0) && !clash && !(mbusy[id] && msrc[id] == i);
    end
  endtask

  initial begin
    for (int e = 0; e < T; e++) begin mbusy[e] = 0; msrc[e] = 0; end
    mptr = N - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R12: idle outputs after reset
    chk("R12 up_req_ready", up_req_ready, 0);
    chk("R12 dn_req_valid", dn_req_valid, 0);
    chk("R12 up_snp_valid", up_snp_valid, 0);
    chk("R12 up_rsp_valid", up_rsp_valid, 0);
    chk("R12 up_fill_valid", up_fill_valid, 0);
    chk("R12 dn_sresp_valid", dn_sresp_valid, 0);
    // R12: first search starts at port 0
    @(negedge clk);
    up_req_valid = 3'b111; dn_req_ready = '1;
    #2;
    chk("R12 R11 first grant", up_req_ready, 1);
    model_step();
    for (int c = 0; c < CYCLES; c++) begin
      @(negedge clk);
      drive_random();
      #2;
      model_step();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule